// File: doc/BRIEF.md
# Triggered One-Pulse Timer

This block is a single-channel 16-bit counter that stays parked until a trigger strobe arrives. The trigger starts the count from a value loaded in advance. One output pulse then follows: it goes active when the counter reaches the compare value and ends at the reload point, where the counter's update event fires. With one-pulse operation enabled, that update event also stops the counter. Without it, the counter keeps cycling and the output repeats every period.

Software sets the block up through a small write port. It selects the direction, one-pulse operation and the output style (level-compare or toggle-on-match). It also loads the counter, fills the compare and reload shadows and fires an update strobe that commits those shadows. The output is driven only when the loaded start value and the compare value form a valid delayed pulse for the chosen direction. Two sticky flags record compare matches and update events, and software clears them by writing ones.

Top module: `pulse_timer`

## Requirements
- R1: After reset the count is 0, the counter is stopped, the output is low, both flags are clear and the control, compare and reload settings are 0.
- R2: While stopped, the counter holds its value, except for software writes. A one-cycle `trig` high while stopped sets `running` at the next edge, and counting begins from the value held at that edge.
- R3: Counting up (control bit 0 = 0), the count rises by one each cycle. When it equals the active reload value, an update event wraps the count to 0. If one-pulse operation is enabled (control bit 1 = 1), that event also stops the counter.
- R4: Counting down (control bit 0 = 1), the count falls by one each cycle. At 0, an update event reloads the count with the reload value, and with one-pulse operation enabled it also stops the counter.
- R5: In level mode (control bit 2 = 1) counting up, the output is high exactly while running with count ≥ compare. The pulse therefore starts compare − start cycles after the counter starts and lasts reload − compare + 1 cycles.
- R6: In level mode counting down, the output is high exactly while running with count ≤ compare, so the pulse lasts compare + 1 cycles.
- R7: The pulse is enabled only when, at the trigger, start < compare ≤ reload (up) or start > compare (down). Otherwise the output stays low for the whole run.
- R8: In toggle mode (control bit 2 = 0), the output inverts on the edge after each compare match while running. It returns low on the edge that stops the counter, and it is never high while the counter is stopped.
- R9: A trigger that arrives while the counter is running has no effect on the count or the run.
- R10: Writes to the compare shadow (address 2) and the reload shadow (address 3) reach the active values only at an update event.
- R11: A write to address 4 is a software update. It loads the count with 0 (up) or the reload shadow (down), commits both shadows and sets the update flag. It does not start a stopped counter, and with one-pulse operation enabled it stops a running one.
- R12: With one-pulse operation disabled, the counter keeps running through update events. The output pattern then repeats every reload + 1 cycles.
- R13: `flag_match` sets on every compare match while running, and `flag_update` sets on every update event. A write to address 5 clears `flag_match` where bit 0 is 1 and `flag_update` where bit 1 is 1, and a set in the same cycle wins over the clear.
- R14: Address 0 writes the control bits, and address 1 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration address |
| wr_data | input | CNT_W | Configuration write data |
| trig | input | 1 | Start trigger, sampled each cycle |
| pulse_out | output | 1 | Pulse output |
| count | output | CNT_W | Current counter value |
| running | output | 1 | Counter is running |
| flag_match | output | 1 | Sticky compare-match flag |
| flag_update | output | 1 | Sticky update-event flag |

## Verification
Two pairs of events can land on the same cycle. A compare match can coincide with a write-one-to-clear of the match flag. A software update strobe can coincide with a running counter in one-pulse operation. The bench times the clear write to the exact cycle in which the count equals the compare value and expects the flag to read set afterwards. It fires the update strobe mid-run and expects the counter stopped at the reloaded value. Sweeps over start, compare and reload values in both directions are judged against pulse delay, width and run length computed from the requirement formulas.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_LOAD = 3'd1,
    A_CMP  = 3'd2,
    A_ARR  = 3'd3,
    A_UPD  = 3'd4,
    A_CLR  = 3'd5
  } pt_addr_e;

  // bit 2 level mode, bit 1 one-pulse, bit 0 count down
  typedef struct packed {
    logic lvl;
    logic opm;
    logic down;
  } pt_ctrl_t;

  function automatic logic start_legal(logic down, int unsigned start,
                                       int unsigned cmp, int unsigned arr);
    if (down) return start > cmp;
    return (start < cmp) && (cmp <= arr);
  endfunction

  function automatic logic level_active(logic down, int unsigned cnt,
                                        int unsigned cmp);
    return down ? (cnt <= cmp) : (cnt >= cmp);
  endfunction

  function automatic int unsigned reload_value(logic down, int unsigned arr);
    return down ? arr : 0;
  endfunction

endpackage

// File: rtl/pt_regs.sv
`timescale 1ns/1ps
module pt_regs
  import pt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             dir_down,
  output logic             opm_en,
  output logic             lvl_mode,
  output logic [CNT_W-1:0] cmp_sh,
  output logic [CNT_W-1:0] arr_sh,
  output logic             load_we,
  output logic             sw_upd,
  output logic             clr_match,
  output logic             clr_update
);

  pt_ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_sh <= '0;
      arr_sh <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= pt_ctrl_t'(wr_data[2:0]);
      if (wr_addr == A_CMP)  cmp_sh <= wr_data;
      if (wr_addr == A_ARR)  arr_sh <= wr_data;
    end
  end

  assign dir_down   = ctrl_q.down;
  assign opm_en     = ctrl_q.opm;
  assign lvl_mode   = ctrl_q.lvl;
  assign load_we    = wr_en && (wr_addr == A_LOAD);
  assign sw_upd     = wr_en && (wr_addr == A_UPD);
  assign clr_match  = wr_en && (wr_addr == A_CLR) && wr_data[0];
  assign clr_update = wr_en && (wr_addr == A_CLR) && wr_data[1];

endmodule

// File: rtl/pt_counter.sv
`timescale 1ns/1ps
module pt_counter
  import pt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_down,
  input  logic             opm_en,
  input  logic [CNT_W-1:0] cmp_sh,
  input  logic [CNT_W-1:0] arr_sh,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             sw_upd,
  input  logic             trig,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             legal,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] arr_act,
  output logic             hw_upd,
  output logic             hw_match,
  output logic             upd_evt,
  output logic             stop_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic start_evt;

  assign start_evt = trig && !run;
  assign hw_upd    = run && (dir_down ? (cnt == '0) : (cnt == arr_act));
  assign hw_match  = run && (cnt == cmp_act);
  assign upd_evt   = hw_upd || sw_upd;
  assign stop_evt  = run && upd_evt && opm_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      legal <= 1'b0;
    end else if (start_evt) begin
      run   <= 1'b1;
      legal <= start_legal(dir_down, 32'(cnt), 32'(cmp_act), 32'(arr_act));
    end else if (stop_evt) begin
      run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (load_we) cnt <= load_val;
    else if (upd_evt) cnt <= CNT_W'(reload_value(dir_down, 32'(arr_sh)));
    else if (run)     cnt <= dir_down ? cnt - ONE : cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act <= '0;
      arr_act <= '0;
    end else if (upd_evt) begin
      cmp_act <= cmp_sh;
      arr_act <= arr_sh;
    end
  end

endmodule

// File: rtl/pt_output.sv
`timescale 1ns/1ps
module pt_output
  import pt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_down,
  input  logic             lvl_mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic             run,
  input  logic             legal,
  input  logic             hw_match,
  input  logic             upd_evt,
  input  logic             stop_evt,
  input  logic             clr_match,
  input  logic             clr_update,
  output logic             pulse_out,
  output logic             flag_match,
  output logic             flag_update
);

  logic lvl_q;
  logic tog_q;

  assign lvl_q = run && legal && level_active(dir_down, 32'(cnt), 32'(cmp_act));

  always_ff @(posedge clk) begin
    if (!rst_n)                             tog_q <= 1'b0;
    else if (stop_evt)                      tog_q <= 1'b0;
    else if (hw_match && legal && !lvl_mode) tog_q <= !tog_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_match  <= 1'b0;
      flag_update <= 1'b0;
    end else begin
      flag_match  <= (flag_match && !clr_match) || hw_match;
      flag_update <= (flag_update && !clr_update) || upd_evt;
    end
  end

  assign pulse_out = lvl_mode ? lvl_q : tog_q;

endmodule

// File: rtl/pulse_timer.sv
`timescale 1ns/1ps
module pulse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig,
  output logic             pulse_out,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             flag_match,
  output logic             flag_update
);

  logic             dir_down, opm_en, lvl_mode;
  logic [CNT_W-1:0] cmp_sh, arr_sh, cmp_act, arr_act;
  logic             load_we, sw_upd, clr_match, clr_update;
  logic             legal, hw_upd, hw_match, upd_evt, stop_evt;

  pt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dir_down(dir_down), .opm_en(opm_en),
    .lvl_mode(lvl_mode), .cmp_sh(cmp_sh), .arr_sh(arr_sh),
    .load_we(load_we), .sw_upd(sw_upd), .clr_match(clr_match),
    .clr_update(clr_update)
  );

  pt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .dir_down(dir_down), .opm_en(opm_en),
    .cmp_sh(cmp_sh), .arr_sh(arr_sh), .load_we(load_we),
    .load_val(wr_data), .sw_upd(sw_upd), .trig(trig), .cnt(count),
    .run(running), .legal(legal), .cmp_act(cmp_act), .arr_act(arr_act),
    .hw_upd(hw_upd), .hw_match(hw_match), .upd_evt(upd_evt),
    .stop_evt(stop_evt)
  );

  pt_output #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .dir_down(dir_down), .lvl_mode(lvl_mode),
    .cnt(count), .cmp_act(cmp_act), .run(running), .legal(legal),
    .hw_match(hw_match), .upd_evt(upd_evt), .stop_evt(stop_evt),
    .clr_match(clr_match), .clr_update(clr_update),
    .pulse_out(pulse_out), .flag_match(flag_match),
    .flag_update(flag_update)
  );

endmodule

// File: rtl/pulse_timer_chk.sv
`timescale 1ns/1ps
module pulse_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             trig,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic             pulse_out,
  input logic             flag_match,
  input logic             dir_down,
  input logic             opm_en,
  input logic             legal,
  input logic [CNT_W-1:0] cmp_act,
  input logic [CNT_W-1:0] arr_act,
  input logic             hw_upd,
  input logic             hw_match,
  input logic             upd_evt,
  input logic             sw_upd
);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !trig && !wr_en |=> !running && $stable(count));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running && trig |=> running);

  p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running && !dir_down && !hw_upd && !wr_en |=>
      count == CNT_W'($past(count) + 1'b1));

  p_opm_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running && opm_en && hw_upd |=> !running);

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && dir_down && !hw_upd && !wr_en |=>
      count == CNT_W'($past(count) - 1'b1));

  p_down_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running && dir_down && hw_upd && !wr_en |=> count == arr_act);

  p_illegal_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running && !legal |-> !pulse_out);

  p_stop_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pulse_out);

  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(cmp_act) && $stable(arr_act));

  p_sw_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running && sw_upd && !trig |=> !running);

  p_match_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    hw_match |=> flag_match);

endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .trig(trig),
  .running(running), .count(count), .pulse_out(pulse_out),
  .flag_match(flag_match), .dir_down(dir_down), .opm_en(opm_en),
  .legal(legal), .cmp_act(cmp_act), .arr_act(arr_act),
  .hw_upd(hw_upd), .hw_match(hw_match), .upd_evt(upd_evt),
  .sw_upd(sw_upd)
);

// File: tb/pulse_timer_test.sv
`timescale 1ns/1ps
module pulse_timer_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         trig = 1'b0;
  logic         pulse_out, running, flag_match, flag_update;
  logic [W-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  pulse_timer #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig(trig), .pulse_out(pulse_out),
    .count(count), .running(running), .flag_match(flag_match),
    .flag_update(flag_update)
  );

  always #2 clk = !clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic setup(input int ctl, input int cmp, input int arr, input int start);
    wr(3'd0, ctl);
    wr(3'd2, cmp);
    wr(3'd3, arr);
    wr(3'd4, 0);
    wr(3'd5, 3);
    wr(3'd1, start);
  endtask

  task automatic fire();
    trig = 1'b1;
    tick();
    trig = 1'b0;
  endtask

  task automatic measure(output int len, output int hi, output int first);
    len = 0; hi = 0; first = -1;
    while (running && len < 300) begin
      if (pulse_out) begin
        if (first < 0) first = len;
        hi++;
      end
      tick();
      len++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int len, hi, first;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 pulse", int'(pulse_out), 0);
    chk("R1 flags", int'({flag_match, flag_update}), 0);
    // R2 idle hold without trigger
    repeat (5) tick();
    chk("R2 idle running", int'(running), 0);
    chk("R2 idle count", int'(count), 0);

    // R5 R7 R3 up-count level sweep, reload 5
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 7; c++) begin
        bit ok;
        ok = (s < c) && (c <= 5);
        setup(6, c, 5, s);
        chk("R14 preload", int'(count), s);
        fire();
        chk("R2 started", int'(running), 1);
        measure(len, hi, first);
        chk("R3 run length", len, 5 - s + 1);
        chk("R5 R7 pulse width", hi, ok ? 5 - c + 1 : 0);
        if (ok) chk("R5 pulse delay", first, c - s);
        chk("R3 wrap to zero", int'(count), 0);
      end
    end

    // R6 R7 R4 down-count level sweep, reload 5
    for (int s = 2; s < 6; s++) begin
      for (int c = 0; c < 6; c++) begin
        bit ok;
        ok = s > c;
        setup(7, c, 5, s);
        fire();
        measure(len, hi, first);
        chk("R4 run length", len, s + 1);
        chk("R6 R7 pulse width", hi, ok ? c + 1 : 0);
        if (ok) chk("R6 pulse delay", first, s - c);
        chk("R4 reload after stop", int'(count), 5);
        chk("R4 stopped", int'(running), 0);
      end
    end

    // R8 toggle mode, up, one-pulse
    setup(2, 3, 6, 0);
    fire();
    measure(len, hi, first);
    chk("R8 toggle width", hi, 3);
    chk("R8 toggle delay", first, 4);
    chk("R8 low after stop", int'(pulse_out), 0);
    setup(2, 0, 6, 0);
    fire();
    measure(len, hi, first);
    chk("R8 R7 illegal toggle", hi, 0);

    // R9 R10 ignored trigger and shadow hold
    setup(6, 1, 9, 0);
    fire();
    repeat (3) tick();
    fire();
    chk("R9 trigger ignored", int'(count), 4);
    wr(3'd3, 4);
    measure(len, hi, first);
    chk("R10 old reload kept", len, 5);
    wr(3'd1, 0);
    fire();
    measure(len, hi, first);
    chk("R10 new reload used", len, 5);

    // R11 software update while stopped, down
    wr(3'd0, 1);
    wr(3'd3, 7);
    wr(3'd5, 3);
    wr(3'd4, 0);
    chk("R11 reload count", int'(count), 7);
    chk("R11 no start", int'(running), 0);
    chk("R11 update flag", int'(flag_update), 1);
    // R11 software update stops one-pulse run
    setup(6, 2, 9, 0);
    fire();
    repeat (2) tick();
    wr(3'd4, 0);
    chk("R11 stop running", int'(running), 0);
    chk("R11 stop count", int'(count), 0);

    // R12 repetitive mode, cmp 2 reload 3
    setup(4, 2, 3, 0);
    fire();
    for (int k = 0; k < 12; k++) begin
      chk("R12 count", int'(count), k % 4);
      chk("R12 output", int'(pulse_out), (k % 4 >= 2) ? 1 : 0);
      tick();
    end
    wr(3'd0, 6);
    measure(len, hi, first);
    chk("R12 stop after opm set", len, 3);

    // R13 match coinciding with clear: set wins
    setup(6, 3, 6, 0);
    fire();
    repeat (3) tick();
    chk("R13 at match count", int'(count), 3);
    wr(3'd5, 1);
    chk("R13 set wins over clear", int'(flag_match), 1);
    wr(3'd5, 1);
    chk("R13 clear", int'(flag_match), 0);
    measure(len, hi, first);
    chk("R13 update flag set", int'(flag_update), 1);
    wr(3'd5, 2);
    chk("R13 update flag clear", int'(flag_update), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule